// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that measures time against an external free-running 64-bit system counter. It keeps an absolute 64-bit deadline. Every refresh moves the deadline to the present counter value plus a programmable 32-bit interval.

If software stays silent for one interval, the block raises an interrupt-level warning. It then sets a new deadline one interval further on. If the watchdog is still not refreshed when that second deadline passes, the block raises a reset-level signal.

Two register ports face software. The refresh port has a single register, and any write to it counts as a refresh. The control port holds these registers:

- control/status
- interval
- deadline, as two 32-bit halves
- a fixed identification word

Writing control/status is a refresh. Writing the interval is a refresh only while the watchdog runs.

The second-stage status flag sits on its own power-on reset. After the watchdog has reset the system, software can still read that flag and tell that the watchdog caused the reset.

Top module: `wdog_two_stage`

## Requirements
- R1: After both resets, control/status reads 0, the deadline reads 0 and both stage outputs are low.
- R2: A read of control offset 0xFCC returns the ID_VALUE parameter, and a read of an unmapped offset returns 0.
- R3: A write to refresh offset 0x000, whatever its data, loads the deadline with counter + interval and clears the first-stage flag (control/status bit 1).
- R4: A write to control offset 0x000 takes bit 0 as the enable and acts as a refresh. Bits 1 (first stage) and 2 (second stage) cannot be set by a write.
- R5: A write to the interval at control offset 0x008 refreshes with the new interval while enabled. While disabled, it leaves the deadline unchanged.
- R6: Once the sampled counter reaches or passes the deadline with the first-stage flag clear, the flag sets in that cycle, stage1_irq rises, and the deadline becomes counter + interval. With a counter that advances by one per cycle, this happens exactly one interval after the refresh.
- R7: When the deadline is reached again with the first-stage flag set, the second-stage flag (bit 2) sets and stage2_rst rises, two intervals after the refresh. The second-stage flag then stays set.
- R8: While the enable is 0, both stage outputs are low and no deadline is evaluated.
- R9: The system reset rst_n clears the enable, the first-stage flag, the interval and the deadline, but not the second-stage flag. Only por_n clears the second-stage flag.
- R10: The deadline can be read and written as two halves: bits 31:0 at control offset 0x010 and bits 63:32 at 0x014.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| por_n | input | 1 | Active-low power-on reset; also clears the second-stage flag |
| cnt_i | input | 64 | Free-running system counter |
| rf_wr | input | 1 | Refresh-port write strobe |
| rf_addr | input | ADDR_W | Refresh-port byte offset |
| cf_wr | input | 1 | Control-port write strobe |
| cf_addr | input | ADDR_W | Control-port byte offset, for both read and write |
| cf_wdata | input | 32 | Control-port write data |
| cf_rdata | output | 32 | Control-port read data (combinational) |
| stage1_irq | output | 1 | First-stage interrupt level |
| stage2_rst | output | 1 | Second-stage reset level |

## Verification
The main timing function is swept over every interval from 1 to 6, with the counter started just below a 32-bit boundary. The sweep checks the output cycle by cycle, so an off-by-one in either stage, or a deadline reload that adds the wrong amount, shows up at a distinct cycle.

Periodic pings shorter than the interval tell a working refresh from one that is ignored. A ping placed after the first stage checks that the full interval is restored. Interval writes, made once while enabled and once while disabled, are compared through the deadline readback to tell the two paths apart. A system reset without a power-on reset separates the sticky second-stage flag from the other state.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] ID_VALUE = 32'h0005_A11D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [63:0]       cnt_i,
  input  logic              rf_wr,
  input  logic [ADDR_W-1:0] rf_addr,
  input  logic              cf_wr,
  input  logic [ADDR_W-1:0] cf_addr,
  input  logic [31:0]       cf_wdata,
  output logic [31:0]       cf_rdata,
  output logic              stage1_irq,
  output logic              stage2_rst
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_OFS  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_CMPL = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_CMPH = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(12'hFCC);

  logic        en_q, ws0_q, ws1_q;
  logic [31:0] ofs_q;
  logic [63:0] cmp_q;

  wire ctrl_wr = cf_wr && (cf_addr == A_CTRL);
  wire ofs_wr  = cf_wr && (cf_addr == A_OFS);
  wire cmpl_wr = cf_wr && (cf_addr == A_CMPL);
  wire cmph_wr = cf_wr && (cf_addr == A_CMPH);
  wire refresh = (rf_wr && rf_addr == '0) || ctrl_wr || (ofs_wr && en_q);
  wire [31:0] ofs_nxt = ofs_wr ? cf_wdata : ofs_q;
  wire expired = en_q && !refresh && (cnt_i >= cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ws0_q <= 1'b0;
      ofs_q <= '0;
      cmp_q <= '0;
    end else begin
      if (ctrl_wr) en_q  <= cf_wdata[0];
      if (ofs_wr)  ofs_q <= cf_wdata;
      if (refresh) begin
        cmp_q <= cnt_i + {32'b0, ofs_nxt};
        ws0_q <= 1'b0;
      end else if (cmpl_wr) begin
        cmp_q[31:0] <= cf_wdata;
      end else if (cmph_wr) begin
        cmp_q[63:32] <= cf_wdata;
      end else if (expired && !ws0_q) begin
        cmp_q <= cnt_i + {32'b0, ofs_q};
        ws0_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                ws1_q <= 1'b0;
    else if (expired && ws0_q) ws1_q <= 1'b1;
  end

  always_comb begin
    unique case (cf_addr)
      A_CTRL:  cf_rdata = {29'b0, ws1_q, ws0_q, en_q};
      A_OFS:   cf_rdata = ofs_q;
      A_CMPL:  cf_rdata = cmp_q[31:0];
      A_CMPH:  cf_rdata = cmp_q[63:32];
      A_ID:    cf_rdata = ID_VALUE;
      default: cf_rdata = '0;
    endcase
  end

  assign stage1_irq = en_q & ws0_q;
  assign stage2_rst = en_q & ws1_q;
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic [63:0]       cnt_i,
  input logic              rf_wr,
  input logic [ADDR_W-1:0] rf_addr,
  input logic              stage1_irq,
  input logic              en_q,
  input logic              ws0_q,
  input logic              ws1_q,
  input logic [31:0]       ofs_q,
  input logic [63:0]       cmp_q
);
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    stage1_irq |-> en_q); // R8
  AST_NO_RISE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !en_q |=> !$rose(ws0_q)); // R8
  AST_PING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rf_wr && rf_addr == '0) |=> !ws0_q); // R3
  AST_RELOAD_ON_WARN: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(ws0_q) |-> (cmp_q == $past(cnt_i) + {32'b0, ofs_q})); // R6
  AST_RESET_AFTER_WARN: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(ws1_q) |-> ws0_q); // R7
  AST_WS1_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    ws1_q |=> ws1_q); // R9
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/wdog_two_stage_tb_top.sv
module wdog_two_stage_tb_top;
  localparam int AW = 12;
  localparam logic [31:0] IDV = 32'h0005_A11D;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic [63:0] cnt = 64'h0000_0001_FFFF_FFF0;
  logic rf_wr = 1'b0, cf_wr = 1'b0;
  logic [AW-1:0] rf_addr = '0, cf_addr = '0;
  logic [31:0] cf_wdata = '0, cf_rdata;
  logic stage1_irq, stage2_rst;
  int n_chk = 0, n_bad = 0;

  always #5ns clk = ~clk;
  always @(posedge clk) cnt <= cnt + 64'd1;

  wdog_two_stage #(.ADDR_W(AW), .ID_VALUE(IDV)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cnt_i(cnt),
    .rf_wr(rf_wr), .rf_addr(rf_addr),
    .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_wdata(cf_wdata), .cf_rdata(cf_rdata),
    .stage1_irq(stage1_irq), .stage2_rst(stage2_rst));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic full_reset();
    @(negedge clk); rst_n = 1'b0; por_n = 1'b0;
    step(2); rst_n = 1'b1; por_n = 1'b1;
  endtask

  task automatic cwrite(input logic [AW-1:0] a, input logic [31:0] d);
    cf_addr = a; cf_wdata = d; cf_wr = 1'b1;
    @(negedge clk); cf_wr = 1'b0;
  endtask

  task automatic ping();
    rf_addr = '0; rf_wr = 1'b1;
    @(negedge clk); rf_wr = 1'b0;
  endtask

  task automatic cread(input logic [AW-1:0] a, output logic [31:0] d);
    cf_addr = a; #1ns; d = cf_rdata;
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] v;
    full_reset();
    // R1 reset state
    cread(12'h000, rd); check("R1 ctrl", rd, 0);
    cread(12'h010, rd); check("R1 cmp lo", rd, 0);
    check("R1 outputs", {stage1_irq, stage2_rst}, 0);
    // R2 id and unmapped
    cread(12'hFCC, rd); check("R2 id", rd, IDV);
    cread(12'h020, rd); check("R2 unmapped", rd, 0);
    // R10 deadline halves
    cwrite(12'h010, 32'hDEAD_BEEF); cwrite(12'h014, 32'h1234_5678);
    cread(12'h010, rd); check("R10 lo", rd, 32'hDEAD_BEEF);
    cread(12'h014, rd); check("R10 hi", rd, 32'h1234_5678);
    // R5 interval write while disabled leaves deadline
    cwrite(12'h008, 32'd9);
    cread(12'h010, rd); check("R5 disabled", rd, 32'hDEAD_BEEF);
    // R4 status bits not writable
    cwrite(12'h000, 32'h6);
    cread(12'h000, rd); check("R4 readonly", rd, 0);

    // R6/R7 sweep over intervals
    for (int ofs = 1; ofs <= 6; ofs++) begin
      full_reset();
      cwrite(12'h008, ofs);
      cwrite(12'h000, 32'h1);
      for (int k = 1; k <= ofs; k++) begin
        step(1);
        check($sformatf("R6 ofs%0d k%0d", ofs, k), stage1_irq, (k >= ofs));
      end
      for (int k = 1; k <= ofs; k++) begin
        step(1);
        check($sformatf("R7 ofs%0d k%0d", ofs, k), stage2_rst, (k >= ofs));
      end
      step(3);
      check("R7 sticky", stage2_rst, 1);
    end

    // R9 system reset keeps second-stage flag
    @(negedge clk); rst_n = 1'b0; step(1); rst_n = 1'b1;
    cread(12'h000, rd); check("R9 ws1 kept", rd, 32'h4);
    check("R9 outputs", {stage1_irq, stage2_rst}, 0);
    @(negedge clk); por_n = 1'b0; step(1); por_n = 1'b1;
    cread(12'h000, rd); check("R9 por clears", rd, 0);

    // R5 interval write while enabled refreshes
    full_reset();
    cwrite(12'h000, 32'h1);
    v = cnt;
    cwrite(12'h008, 32'd7);
    cread(12'h010, rd); check("R5 enabled lo", rd, v[31:0] + 32'd7);
    cread(12'h014, rd); check("R5 enabled hi", rd, (v + 64'd7) >> 32);

    // R3 pinging holds off, ping after warning restores full interval
    full_reset();
    cwrite(12'h008, 32'd5);
    cwrite(12'h000, 32'h1);
    for (int i = 0; i < 10; i++) begin step(2); ping(); end
    check("R3 held off", stage1_irq, 0);
    step(5);
    check("R3 warn", stage1_irq, 1);
    v = cnt;
    ping();
    check("R3 clears", stage1_irq, 0);
    cread(12'h010, rd); check("R3 deadline", rd, v[31:0] + 32'd5);
    step(4); check("R3 before", stage1_irq, 0);
    step(1); check("R3 at", stage1_irq, 1);

    // R8 disabled evaluates nothing
    cwrite(12'h000, 32'h0);
    step(20);
    check("R8 outputs", {stage1_irq, stage2_rst}, 0);
    cread(12'h000, rd); check("R8 status", rd, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule